// File: doc/BRIEF.md
# SD command frame engine

This block handles the command half of an SD bus host. A requester supplies a 6-bit command index, a 32-bit argument and the response type it expects, then pulses `req`. The engine shifts a 48-bit command frame out on the CMD line, MSB first, with a CRC7 it computes itself. It then releases the line and waits for the card to answer. The reply is captured bit by bit and its CRC and header are checked. The engine then signals completion with one of four result codes.

The SD clock runs continuously as an integer division of the system clock. The host changes CMD on the falling edge of the SD clock and samples it on the rising edge. One serial CRC7 register serves both directions: it builds the outgoing checksum and it checks the incoming one. The reply payload stays on `rsp_short` or `rsp_long` from `done` until the next accepted request.

Top module: `sdcmd_engine`

## Requirements
- R1: The command frame is 48 bits sent MSB first: a 0, a 1, the 6-bit index, the 32-bit argument, the 7-bit CRC and a closing 1. `cmd_oe` is high for exactly these 48 bits, and `cmd_o` changes only when `sd_clk` falls.
- R2: The CRC7 (polynomial x^7+x^3+1, register cleared to zero) covers the first 40 frame bits and sits in frame bits 7:1. Index 0 with argument 0 gives 7'h4A. Index 8 with argument 32'h1AA gives 7'h43.
- R3: `sd_clk` has a period of DIV system clocks (default 5). It is low for DIV/2 of them and high for the rest, and it is low after reset.
- R4: On the falling edge after the closing bit, `cmd_oe` drops. If `rsp_kind` is 0 (no response), `done` pulses for one cycle with result 0 (OK).
- R5: For reply kinds 1 (short), 2 (long) and 3 (short, unchecked), the first 0 sampled on a rising edge starts capture. The engine then takes 48 bits (kinds 1 and 3) or 136 bits (kind 2).
- R6: For kind 1, a mismatch between the CRC7 over the first 40 reply bits and reply bits 7:1 gives result 2 (CRC error). On success, reply bits 39:8 appear on `rsp_short`.
- R7: For kind 1 with a correct CRC, an echoed index (reply bits 45:40) that differs from the issued one gives result 3 (code error). There is no such check when the issued index is 41.
- R8: For kind 2, the CRC7 covers reply bits 127:8 and is compared with bits 7:1; a mismatch gives result 2. If the CRC is correct but the leading byte is not 8'h3F, the result is 3. On success, bits 127:8 appear on `rsp_long`.
- R9: For kind 3, both the CRC check and the index check are skipped. The result is 0 and reply bits 39:8 appear on `rsp_short`.
- R10: If no start bit is seen within TIMEOUT_SDCLK rising edges of `sd_clk`, `done` pulses with result 1 (timeout) and the engine returns to idle, ready for a new request.
- R11: `busy` rises in the cycle after an accepted `req` and falls in the cycle `done` pulses. A `req` while `busy` is high is ignored.
- R12: During reset, `busy`, `done` and `cmd_oe` are 0, `result` is 0 and `sd_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a command (taken only while idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0 none, 1 short, 2 long, 3 short unchecked |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 timeout, 2 CRC error, 3 code error |
| rsp_short | output | 32 | Payload of a 48-bit reply |
| rsp_long | output | 120 | Payload of a 136-bit reply |
| sd_clk | output | 1 | SD bus clock |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line input value |

## Verification
A card model in the bench decodes every frame the engine sends and compares it with a frame the bench builds itself. Two frames are also checked against published CRC constants, which separates a wrong polynomial or wrong bit coverage from a wrong bit order. Each reply kind is tried three ways: a clean reply, a reply with one flipped CRC bit, and a reply with a wrong index or header. This shows that the CRC check comes before the code check and that each kind checks the right span. The index-41 exemption, the unchecked kind and a silent card (timeout followed by a fresh request) cover the remaining paths. Directed tests measure the `sd_clk` duty cycle and send a second request while the engine is busy.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   typedef enum logic [1:0] {
      RSP_NONE      = 2'd0,
      RSP_SHORT     = 2'd1,
      RSP_LONG      = 2'd2,
      RSP_SHORT_RAW = 2'd3
   } rsp_kind_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_CRC     = 2'd2,
      RES_CODE    = 2'd3
   } result_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_CHECK
   } state_e;

   localparam int unsigned FRAME_BITS    = 48;
   localparam int unsigned BODY_BITS     = 40;
   localparam int unsigned CRC_W         = 7;
   localparam logic [6:0]  CRC_POLY      = 7'h09;
   localparam int unsigned SHORT_BITS    = 48;
   localparam int unsigned LONG_BITS     = 136;
   localparam int unsigned LONG_HDR_BITS = 8;
   localparam logic [7:0]  LONG_HDR      = 8'h3F;
   localparam logic [5:0]  IDX_EXEMPT    = 6'd41;
endpackage

// File: rtl/sdcmd_clkdiv.sv
module sdcmd_clkdiv #(
   parameter int unsigned DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic sd_clk,
   output logic fall_stb,
   output logic rise_stb
);
   localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int unsigned HALF = DIV / 2;

   if (DIV < 2) begin : g_bad_div
      $error("sdcmd_clkdiv: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign fall_stb = (cnt == CW'(DIV - 1));
   assign rise_stb = (cnt == CW'(HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         sd_clk <= 1'b0;
      end else begin
         cnt <= fall_stb ? '0 : cnt + 1'b1;
         if (fall_stb)      sd_clk <= 1'b0;
         else if (rise_stb) sd_clk <= 1'b1;
      end
   end
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
   parameter int unsigned W    = 7,
   parameter logic [W-1:0] POLY = 7'h09
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   if (W < 2) begin : g_bad_w
      $error("sdcmd_crc7: W must be at least 2");
   end

   logic fb;
   assign fb = crc[W-1] ^ din;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) crc <= '0;
      else if (en)       crc <= {crc[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
   end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
   import sdcmd_pkg::*;
#(
   parameter int unsigned DIV           = 5,
   parameter int unsigned TIMEOUT_SDCLK = 4096
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req,
   input  logic [5:0]   cmd_idx,
   input  logic [31:0]  cmd_arg,
   input  logic [1:0]   rsp_kind,
   output logic         busy,
   output logic         done,
   output logic [1:0]   result,
   output logic [31:0]  rsp_short,
   output logic [119:0] rsp_long,
   output logic         sd_clk,
   output logic         cmd_o,
   output logic         cmd_oe,
   input  logic         cmd_i
);
   localparam int unsigned BW = $clog2(LONG_BITS + 1);
   localparam int unsigned TW = $clog2(TIMEOUT_SDCLK + 1);

   if (TIMEOUT_SDCLK < 1) begin : g_bad_timeout
      $error("sdcmd_engine: TIMEOUT_SDCLK must be at least 1");
   end

   logic fall_stb, rise_stb;
   logic crc_clr, crc_en, crc_din;
   logic [CRC_W-1:0] crc_val;

   state_e              state;
   rsp_kind_e           kind_q;
   result_e             result_q;
   logic [5:0]          idx_q;
   logic [BODY_BITS-1:0] tx_sh;
   logic [LONG_BITS-1:0] rx_sh;
   logic [BW-1:0]       bit_n;
   logic [TW-1:0]       to_cnt;
   logic [BW-1:0]       rsp_last;
   logic [BW-1:0]       crc_off;
   logic                unused_rx_bit;

   sdcmd_clkdiv #(.DIV(DIV)) u_clkdiv (
      .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk),
      .fall_stb(fall_stb), .rise_stb(rise_stb)
   );

   sdcmd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
      .din(crc_din), .crc(crc_val)
   );

   assign busy          = (state != ST_IDLE);
   assign result        = result_q;
   assign rsp_short     = rx_sh[SHORT_BITS-9:8];
   assign rsp_long      = rx_sh[LONG_BITS-9:8];
   assign unused_rx_bit = rx_sh[0];
   assign rsp_last      = (kind_q == RSP_LONG) ? BW'(LONG_BITS - 1) : BW'(SHORT_BITS - 1);
   assign crc_off       = BW'(FRAME_BITS - 2) - bit_n;

   // One CRC register: builds the frame checksum, then checks the reply.
   always_comb begin
      crc_clr = 1'b0;
      crc_en  = 1'b0;
      crc_din = cmd_i;
      unique case (state)
         ST_IDLE: crc_clr = req;
         ST_SEND: begin
            crc_din = tx_sh[BODY_BITS-1];
            crc_en  = fall_stb && (bit_n < BW'(BODY_BITS));
            crc_clr = fall_stb && (bit_n == BW'(FRAME_BITS));
         end
         ST_WAIT: crc_en = rise_stb && !cmd_i && (kind_q != RSP_LONG);
         ST_RECV: crc_en = rise_stb &&
                  ((kind_q == RSP_LONG) ?
                   ((bit_n >= BW'(LONG_HDR_BITS)) && (bit_n < BW'(LONG_BITS - 8))) :
                   (bit_n < BW'(BODY_BITS)));
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind_q   <= RSP_NONE;
         result_q <= RES_OK;
         idx_q    <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         bit_n    <= '0;
         to_cnt   <= '0;
         cmd_o    <= 1'b1;
         cmd_oe   <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (req) begin
               kind_q <= rsp_kind_e'(rsp_kind);
               idx_q  <= cmd_idx;
               tx_sh  <= {2'b01, cmd_idx, cmd_arg};
               rx_sh  <= '0;
               bit_n  <= '0;
               state  <= ST_SEND;
            end
            ST_SEND: if (fall_stb) begin
               bit_n <= bit_n + 1'b1;
               if (bit_n < BW'(BODY_BITS)) begin
                  cmd_oe <= 1'b1;
                  cmd_o  <= tx_sh[BODY_BITS-1];
                  tx_sh  <= {tx_sh[BODY_BITS-2:0], 1'b0};
               end else if (bit_n < BW'(FRAME_BITS - 1)) begin
                  cmd_o <= crc_val[crc_off[2:0]];
               end else if (bit_n == BW'(FRAME_BITS - 1)) begin
                  cmd_o <= 1'b1;
               end else begin
                  cmd_oe <= 1'b0;
                  cmd_o  <= 1'b1;
                  to_cnt <= '0;
                  if (kind_q == RSP_NONE) begin
                     result_q <= RES_OK;
                     done     <= 1'b1;
                     state    <= ST_IDLE;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: if (rise_stb) begin
               if (!cmd_i) begin
                  rx_sh <= {rx_sh[LONG_BITS-2:0], 1'b0};
                  bit_n <= BW'(1);
                  state <= ST_RECV;
               end else if (to_cnt == TW'(TIMEOUT_SDCLK - 1)) begin
                  result_q <= RES_TIMEOUT;
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end else begin
                  to_cnt <= to_cnt + 1'b1;
               end
            end
            ST_RECV: if (rise_stb) begin
               rx_sh <= {rx_sh[LONG_BITS-2:0], cmd_i};
               bit_n <= bit_n + 1'b1;
               if (bit_n == rsp_last) state <= ST_CHECK;
            end
            ST_CHECK: begin
               done  <= 1'b1;
               state <= ST_IDLE;
               unique case (kind_q)
                  RSP_SHORT: begin
                     if (crc_val != rx_sh[7:1])
                        result_q <= RES_CRC;
                     else if ((idx_q != IDX_EXEMPT) && (rx_sh[45:40] != idx_q))
                        result_q <= RES_CODE;
                     else
                        result_q <= RES_OK;
                  end
                  RSP_LONG: begin
                     if (crc_val != rx_sh[7:1])
                        result_q <= RES_CRC;
                     else if (rx_sh[LONG_BITS-1:LONG_BITS-8] != LONG_HDR)
                        result_q <= RES_CODE;
                     else
                        result_q <= RES_OK;
                  end
                  default: result_q <= RES_OK;
               endcase
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req,
   input logic       busy,
   input logic       done,
   input logic [1:0] result,
   input logic       sd_clk,
   input logic       cmd_o,
   input logic       cmd_oe
);
   // R11: completion and busy never overlap
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11: an idle request is taken at the next edge
   assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req) |=> busy);

   // R4: completion is a single-cycle pulse
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: the line is driven only inside an exchange
   assert_oe_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_oe |-> busy);

   // R1: host output moves only with a falling SD clock
   assert_drive_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_o) |-> $fell(sd_clk));

   // R6: the result code only changes when an exchange completes
   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
   .result(result), .sd_clk(sd_clk), .cmd_o(cmd_o), .cmd_oe(cmd_oe)
);

// File: tb/test_sdcmd_engine.sv
module test_sdcmd_engine;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 5;
   localparam int NVEC       = 10;

   // {kind[43:42], idx[41:36], arg[35:4], fault[3:2], expected result[1:0]}
   // fault: 0 clean, 1 CRC bit flipped, 2 wrong index or header, 3 card silent
   localparam logic [43:0] VECS [NVEC] = '{
      {2'd0, 6'd0,  32'h00000000, 2'd0, 2'd0},
      {2'd1, 6'd8,  32'h000001AA, 2'd0, 2'd0},
      {2'd1, 6'd17, 32'h12345678, 2'd1, 2'd2},
      {2'd1, 6'd17, 32'hDEADBEEF, 2'd2, 2'd3},
      {2'd1, 6'd41, 32'h40FF8000, 2'd2, 2'd0},
      {2'd2, 6'd2,  32'h00000000, 2'd0, 2'd0},
      {2'd2, 6'd9,  32'h55550000, 2'd1, 2'd2},
      {2'd2, 6'd10, 32'h00010000, 2'd2, 2'd3},
      {2'd1, 6'd55, 32'h00000000, 2'd3, 2'd1},
      {2'd3, 6'd41, 32'h00FF8000, 2'd0, 2'd0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 1'b0;
   logic [5:0]   cmd_idx = '0;
   logic [31:0]  cmd_arg = '0;
   logic [1:0]   rsp_kind = '0;
   logic         busy, done, sd_clk, cmd_o, cmd_oe;
   logic         cmd_i = 1'b1;
   logic [1:0]   result;
   logic [31:0]  rsp_short;
   logic [119:0] rsp_long;

   int n_chk = 0;
   int n_fail = 0;

   // card model configuration, written only by the stimulus process
   logic [1:0]   cfg_kind = '0;
   logic [1:0]   cfg_fault = '0;
   logic [31:0]  cfg_pay32 = '0;
   logic [119:0] cfg_pay120 = '0;

   // card model state, written only by the card process
   logic         sck_prev = 1'b0;
   logic [47:0]  host_frame = '0;
   int           host_bits = 0;
   int           frame_cnt = 0;
   logic [135:0] rsp_vec = '0;
   int           rsp_left = 0;
   int           rsp_gap = 0;
   logic         rsp_armed = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdcmd_engine #(.DIV(DIV)) i_sdcmd_engine (
      .clk(clk), .rst_n(rst_n), .req(req), .cmd_idx(cmd_idx),
      .cmd_arg(cmd_arg), .rsp_kind(rsp_kind), .busy(busy), .done(done),
      .result(result), .rsp_short(rsp_short), .rsp_long(rsp_long),
      .sd_clk(sd_clk), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i)
   );

   function automatic logic [6:0] crc7b(input logic [119:0] d, input int n);
      logic [6:0] c = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic fb = c[6] ^ d[i];
         c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   // Card model: samples the host on sd_clk rise, drives its reply on sd_clk fall.
   always @(negedge clk) begin
      logic [47:0]  fr;
      logic [39:0]  body;
      logic [6:0]   c;
      logic [5:0]   echo;
      if (sd_clk && !sck_prev && cmd_oe) begin
         fr = {host_frame[46:0], cmd_o};
         host_frame <= fr;
         if (host_bits == 47) begin
            host_bits <= 0;
            frame_cnt <= frame_cnt + 1;
            if (cfg_kind != 2'd0 && cfg_fault != 2'd3) begin
               rsp_armed <= 1'b1;
               rsp_gap   <= 2;
               if (cfg_kind == 2'd2) begin
                  c = crc7b(cfg_pay120, 120) ^ ((cfg_fault == 2'd1) ? 7'h01 : 7'h00);
                  rsp_vec  <= {((cfg_fault == 2'd2) ? 8'h3E : 8'h3F), cfg_pay120, c, 1'b1};
                  rsp_left <= 136;
               end else if (cfg_kind == 2'd3) begin
                  rsp_vec  <= {88'h0, 2'b00, 6'h3F, cfg_pay32, 7'h7F, 1'b1};
                  rsp_left <= 48;
               end else begin
                  echo = (cfg_fault == 2'd2) ? (fr[45:40] ^ 6'h01) : fr[45:40];
                  body = {2'b00, echo, cfg_pay32};
                  c = crc7b({80'h0, body}, 40) ^ ((cfg_fault == 2'd1) ? 7'h01 : 7'h00);
                  rsp_vec  <= {88'h0, body, c, 1'b1};
                  rsp_left <= 48;
               end
            end
         end else begin
            host_bits <= host_bits + 1;
         end
      end
      if (!sd_clk && sck_prev && rsp_armed) begin
         if (rsp_gap != 0) begin
            rsp_gap <= rsp_gap - 1;
         end else if (rsp_left != 0) begin
            cmd_i    <= rsp_vec[rsp_left-1];
            rsp_left <= rsp_left - 1;
         end else begin
            cmd_i     <= 1'b1;
            rsp_armed <= 1'b0;
         end
      end
      sck_prev <= sd_clk;
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic wait_done(output bit got);
      got = 1'b0;
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         if (done) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   function automatic string tag_of(input logic [1:0] k, input logic [1:0] f);
      if (k == 2'd0) return "R4";
      if (f == 2'd3) return "R10";
      if (k == 2'd3) return "R9";
      if (k == 2'd2) return "R8";
      if (f == 2'd2) return "R7";
      return "R6";
   endfunction

   task automatic issue(input logic [1:0] k, input logic [5:0] idx, input logic [31:0] arg);
      @(negedge clk);
      rsp_kind = k;
      cmd_idx  = idx;
      cmd_arg  = arg;
      req      = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic run_vec(input logic [43:0] v, input int n);
      logic [1:0]   k = v[43:42];
      logic [5:0]   idx = v[41:36];
      logic [31:0]  arg = v[35:4];
      logic [1:0]   f = v[3:2];
      logic [1:0]   ex = v[1:0];
      logic [47:0]  exp_fr;
      int           fc0;
      bit           got;
      string        t = tag_of(k, f);
      cfg_kind   = k;
      cfg_fault  = f;
      cfg_pay32  = arg ^ 32'hC3C3_3C3C;
      cfg_pay120 = {arg, ~arg, arg ^ 32'h0F0F_0F0F, 24'hA5F00D};
      exp_fr = {2'b01, idx, arg, crc7b({80'h0, 2'b01, idx, arg}, 40), 1'b1};
      fc0 = frame_cnt;
      issue(k, idx, arg);
      check(busy == 1'b1, "R11", $sformatf("vec %0d busy after request", n), 128'(busy), 128'(1));
      wait_done(got);
      check(got, t, $sformatf("vec %0d completion", n), 128'(got), 128'(1));
      check(result == ex, t, $sformatf("vec %0d result", n), 128'(result), 128'(ex));
      check(frame_cnt == fc0 + 1, "R1", $sformatf("vec %0d frames sent", n),
            128'(frame_cnt - fc0), 128'(1));
      check(host_frame == exp_fr, "R1", $sformatf("vec %0d frame", n),
            128'(host_frame), 128'(exp_fr));
      if (n == 0)
         check(host_frame[7:1] == 7'h4A, "R2", "CRC of index 0", 128'(host_frame[7:1]), 128'(7'h4A));
      if (n == 1)
         check(host_frame[7:1] == 7'h43, "R2", "CRC of index 8", 128'(host_frame[7:1]), 128'(7'h43));
      if (ex == 2'd0 && (k == 2'd1 || k == 2'd3))
         check(rsp_short == cfg_pay32, "R5", $sformatf("vec %0d short payload", n),
               128'(rsp_short), 128'(cfg_pay32));
      if (ex == 2'd0 && k == 2'd2)
         check(rsp_long == cfg_pay120, "R5", $sformatf("vec %0d long payload", n),
               128'(rsp_long), 128'(cfg_pay120));
      check(cmd_oe == 1'b0 && busy == 1'b0, "R4", $sformatf("vec %0d line released", n),
            128'({cmd_oe, busy}), 128'(0));
      repeat (30) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      int hi;
      int lo;
      int fc0;
      bit got;
      repeat (4) @(negedge clk);
      // R12: reset state
      check({busy, done, cmd_oe, sd_clk} == 4'b0 && result == 2'd0, "R12", "reset state",
            128'({busy, done, cmd_oe, sd_clk, result}), 128'(0));
      rst_n = 1'b1;

      // R3: SD clock shape
      hi = 0;
      lo = 0;
      for (int i = 0; i < 50 && !(sd_clk && !sck_prev); i++) @(negedge clk);
      for (int i = 0; i < 20 && sd_clk; i++) begin hi++; @(negedge clk); end
      for (int i = 0; i < 20 && !sd_clk; i++) begin lo++; @(negedge clk); end
      check(hi == DIV - DIV / 2, "R3", "sd_clk high cycles", 128'(hi), 128'(DIV - DIV / 2));
      check(lo == DIV / 2, "R3", "sd_clk low cycles", 128'(lo), 128'(DIV / 2));

      for (int n = 0; n < NVEC; n++) run_vec(VECS[n], n);

      // R11: a request while busy is ignored
      cfg_kind   = 2'd1;
      cfg_fault  = 2'd0;
      cfg_pay32  = 32'h0BAD_F00D;
      fc0 = frame_cnt;
      issue(2'd1, 6'd13, 32'h0000_1234);
      repeat (3) @(negedge clk);
      issue(2'd0, 6'd7, 32'hFFFF_FFFF);
      wait_done(got);
      check(got && result == 2'd0, "R11", "first request completes",
            128'({got, result}), 128'({1'b1, 2'd0}));
      check(host_frame[45:40] == 6'd13, "R11", "sent index after ignored request",
            128'(host_frame[45:40]), 128'(13));
      repeat (700) @(negedge clk);
      check(frame_cnt == fc0 + 1 && !busy, "R11", "no extra frame from ignored request",
            128'(frame_cnt - fc0), 128'(1));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule